// File: doc/BRIEF.md
# UART Interrupt Identification

This block collects the interrupt conditions of a serial controller and publishes the most urgent one as an 8-bit identification value, together with a single interrupt line. It has seven sources: line status errors, receive data ready, receive timeout, transmit holding empty, modem status change, received Xoff or special character, and CTS/RTS change. The last two are enhanced sources and count only while the enhanced-feature enable is set.

The line status, transmit, modem, Xoff and CTS/RTS sources arrive as one-cycle event pulses. The block latches each of them until the condition that clears it. Receive data ready and receive timeout are levels from the receive path and are used as they stand. Each source is masked by its own enable bit before the priority encoder. The identification value and the interrupt line are both registered, so they stay stable while software reads them.

Top module: `uart_int_ident`

## Requirements
- R1: While reset is asserted, the identification value reads 0x01 and the interrupt line is low.
- R2: When several sources are active, the highest-priority one is reported. The order, most urgent first, is: line status, receive (timeout or data ready), transmit holding empty, modem status, Xoff/special character, CTS/RTS change.
- R3: Identification bits 5..0 are one of these codes: line status 000110, receive timeout 001100, receive data ready 000100, transmit holding empty 000010, modem status 000000, Xoff/special 010000, CTS/RTS change 100000, or 000001 when nothing is active.
- R4: Bit 0 is 0 exactly when an enabled source is active. The interrupt line is high exactly when bit 0 is 0.
- R5: When receive timeout and receive data ready are both active, the timeout code is reported.
- R6: While the enhanced enable is 0, Xoff and CTS/RTS events are not latched and bits 5..4 read 0.
- R7: A latched Xoff indication stays active until an Xon event arrives. Reads of the identification, line status and modem status registers do not clear it.
- R8: Bits 7 and 6 both equal the FIFO-enabled flag.
- R9: A line status read clears the line status source. A modem status read clears both the modem status source and the CTS/RTS source. An event in the same cycle as its clearing read leaves the source set.
- R10: The transmit source is cleared by a transmit write. It is also cleared by an identification read, but only while the transmit code is the one being reported. A new transmit-empty event sets it again.
- R11: The enable vector masks sources before prioritization: bit 0 receive (both kinds), bit 1 transmit, bit 2 line status, bit 3 modem, bit 4 Xoff, bit 5 CTS/RTS. A latched source that is disabled is reported once its enable bit is set.
- R12: Inputs sampled at a clock edge are reflected in both outputs immediately after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineErrEv | input | 1 | Line status error event pulse |
| rxReady | input | 1 | Receive data ready level |
| rxTimeout | input | 1 | Receive timeout level |
| txEmptyEv | input | 1 | Transmit holding empty event pulse |
| modemEv | input | 1 | Modem status change event pulse |
| xoffEv | input | 1 | Xoff or special character received pulse |
| xonEv | input | 1 | Xon received pulse |
| flowEv | input | 1 | CTS/RTS change event pulse |
| srcEn | input | 6 | Per-source enable vector (see R11) |
| enhEn | input | 1 | Enhanced-feature enable |
| fifoEn | input | 1 | FIFOs enabled flag |
| idRd | input | 1 | Identification register read strobe |
| lineRd | input | 1 | Line status register read strobe |
| modemRd | input | 1 | Modem status register read strobe |
| txWr | input | 1 | Transmit data write strobe |
| idVal | output | 8 | Registered identification value |
| irqOut | output | 1 | Registered interrupt line |

## Verification
Every result is due one clock edge after the inputs that cause it: an event, read strobe, level or enable seen at an edge is in the outputs right after that edge, and nothing is delayed further. The bench changes inputs only on falling edges. Its reference model advances on the rising edge, and the comparison takes place on the following falling edge, so each check lands exactly in the cycle where the design's output should have changed. Ordered checks with literal values cover the priority chain, the clearing conditions and the cases where an event and a read fall in the same cycle.

// File: rtl/uart_int_ident_pkg.sv
package uart_int_ident_pkg;
  localparam int ID_W   = 8;
  localparam int CODE_W = 6;
  localparam int EN_W   = 6;
  localparam int STICKY_N = 5;

  // enable vector bit positions
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_XOFF  = 4;
  localparam int EN_FLOW  = 5;

  // sticky source indices
  localparam int S_LINE  = 0;
  localparam int S_TX    = 1;
  localparam int S_MODEM = 2;
  localparam int S_XOFF  = 3;
  localparam int S_FLOW  = 4;

  localparam logic [CODE_W-1:0] CODE_LINE  = 6'b000110;
  localparam logic [CODE_W-1:0] CODE_RXTO  = 6'b001100;
  localparam logic [CODE_W-1:0] CODE_RXRDY = 6'b000100;
  localparam logic [CODE_W-1:0] CODE_TX    = 6'b000010;
  localparam logic [CODE_W-1:0] CODE_MODEM = 6'b000000;
  localparam logic [CODE_W-1:0] CODE_XOFF  = 6'b010000;
  localparam logic [CODE_W-1:0] CODE_FLOW  = 6'b100000;
  localparam logic [CODE_W-1:0] CODE_NONE  = 6'b000001;

  typedef struct packed {
    logic [STICKY_N-1:0] set;
    logic [STICKY_N-1:0] clr;
  } srcStrobe_t;
endpackage

// File: rtl/uart_int_ident_ctrl.sv
module uart_int_ident_ctrl
  import uart_int_ident_pkg::*;
(
  input  logic lineErrEv,
  input  logic txEmptyEv,
  input  logic modemEv,
  input  logic xoffEv,
  input  logic xonEv,
  input  logic flowEv,
  input  logic enhEn,
  input  logic idRd,
  input  logic lineRd,
  input  logic modemRd,
  input  logic txWr,
  input  logic txReported,
  output srcStrobe_t strobes
);
  always_comb begin
    strobes = '0;
    // set strobes; enhanced sources latch only in enhanced mode
    strobes.set[S_LINE]  = lineErrEv;
    strobes.set[S_TX]    = txEmptyEv;
    strobes.set[S_MODEM] = modemEv;
    strobes.set[S_XOFF]  = xoffEv & enhEn;
    strobes.set[S_FLOW]  = flowEv & enhEn;
    // clear strobes
    strobes.clr[S_LINE]  = lineRd;
    strobes.clr[S_TX]    = txWr | (idRd & txReported);
    strobes.clr[S_MODEM] = modemRd;
    strobes.clr[S_XOFF]  = xonEv;
    strobes.clr[S_FLOW]  = modemRd;
  end
endmodule

// File: rtl/uart_int_ident_dp.sv
module uart_int_ident_dp
  import uart_int_ident_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  srcStrobe_t      strobes,
  input  logic            rxReady,
  input  logic            rxTimeout,
  input  logic [EN_W-1:0] srcEn,
  input  logic            enhEn,
  input  logic            fifoEn,
  output logic [ID_W-1:0] idVal,
  output logic            irqOut,
  output logic            txReported
);
  localparam int ACT_N = STICKY_N + 2;

  logic [STICKY_N-1:0] pendQ, pendD;
  logic [ACT_N-1:0]    active;
  logic [CODE_W-1:0]   code;
  logic [ID_W-1:0]     idQ;
  logic                irqQ;

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    assign pendD[i] = strobes.set[i] | (pendQ[i] & ~strobes.clr[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ[i] <= 1'b0;
      else       pendQ[i] <= pendD[i];
    end
  end

  // active vector ordered by priority, index 0 most urgent
  always_comb begin
    active[0] = pendD[S_LINE]  & srcEn[EN_LINE];
    active[1] = rxTimeout      & srcEn[EN_RX];
    active[2] = rxReady        & srcEn[EN_RX];
    active[3] = pendD[S_TX]    & srcEn[EN_TX];
    active[4] = pendD[S_MODEM] & srcEn[EN_MODEM];
    active[5] = pendD[S_XOFF]  & srcEn[EN_XOFF] & enhEn;
    active[6] = pendD[S_FLOW]  & srcEn[EN_FLOW] & enhEn;
  end

  always_comb begin
    if      (active[0]) code = CODE_LINE;
    else if (active[1]) code = CODE_RXTO;
    else if (active[2]) code = CODE_RXRDY;
    else if (active[3]) code = CODE_TX;
    else if (active[4]) code = CODE_MODEM;
    else if (active[5]) code = CODE_XOFF;
    else if (active[6]) code = CODE_FLOW;
    else                code = CODE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idQ  <= {{(ID_W-CODE_W){1'b0}}, CODE_NONE};
      irqQ <= 1'b0;
    end else begin
      idQ  <= {{(ID_W-CODE_W){fifoEn}}, code};
      irqQ <= |active;
    end
  end

  assign idVal      = idQ;
  assign irqOut     = irqQ;
  assign txReported = (idQ[CODE_W-1:0] == CODE_TX);
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_int_ident_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            lineErrEv,
  input  logic            rxReady,
  input  logic            rxTimeout,
  input  logic            txEmptyEv,
  input  logic            modemEv,
  input  logic            xoffEv,
  input  logic            xonEv,
  input  logic            flowEv,
  input  logic [5:0]      srcEn,
  input  logic            enhEn,
  input  logic            fifoEn,
  input  logic            idRd,
  input  logic            lineRd,
  input  logic            modemRd,
  input  logic            txWr,
  output logic [7:0]      idVal,
  output logic            irqOut
);
  srcStrobe_t strobes;
  logic       txReported;

  uart_int_ident_ctrl u_ctrl (
    .lineErrEv (lineErrEv),
    .txEmptyEv (txEmptyEv),
    .modemEv   (modemEv),
    .xoffEv    (xoffEv),
    .xonEv     (xonEv),
    .flowEv    (flowEv),
    .enhEn     (enhEn),
    .idRd      (idRd),
    .lineRd    (lineRd),
    .modemRd   (modemRd),
    .txWr      (txWr),
    .txReported(txReported),
    .strobes   (strobes)
  );

  uart_int_ident_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rxReady   (rxReady),
    .rxTimeout (rxTimeout),
    .srcEn     (srcEn),
    .enhEn     (enhEn),
    .fifoEn    (fifoEn),
    .idVal     (idVal),
    .irqOut    (irqOut),
    .txReported(txReported)
  );
endmodule

// File: rtl/uart_int_ident_chk.sv
module uart_int_ident_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modemEv,
  input logic       txEmptyEv,
  input logic       enhEn,
  input logic       idRd,
  input logic       modemRd,
  input logic [7:0] idVal,
  input logic       irqOut
);
  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    idVal[5:0] inside {6'b000110, 6'b001100, 6'b000100, 6'b000010,
                       6'b000000, 6'b010000, 6'b100000, 6'b000001});
  // R4
  irq_matches_bit0_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == !idVal[0]);
  // R8
  fifo_bits_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    idVal[7] == idVal[6]);
  // R6
  enh_off_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enhEn |=> (idVal[5:4] == 2'b00));
  // R9
  modem_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modemRd && !modemEv) |=> (idVal[5:0] != 6'b000000));
  // R10
  tx_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idRd && idVal[5:0] == 6'b000010 && !txEmptyEv) |=> (idVal[5:0] != 6'b000010));
endmodule

bind uart_int_ident uart_int_ident_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .modemEv  (modemEv),
  .txEmptyEv(txEmptyEv),
  .enhEn    (enhEn),
  .idRd     (idRd),
  .modemRd  (modemRd),
  .idVal    (idVal),
  .irqOut   (irqOut)
);

// File: tb/uart_int_ident_test.sv
module uart_int_ident_test;
  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic lineErrEv = 0, rxReady = 0, rxTimeout = 0, txEmptyEv = 0, modemEv = 0;
  logic xoffEv = 0, xonEv = 0, flowEv = 0;
  logic [5:0] srcEn = 6'h00;
  logic enhEn = 0, fifoEn = 1, idRd = 0, lineRd = 0, modemRd = 0, txWr = 0;
  logic [7:0] idVal;
  logic irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  uart_int_ident uut (
    .clk(clk), .rstN(rstN), .lineErrEv(lineErrEv), .rxReady(rxReady),
    .rxTimeout(rxTimeout), .txEmptyEv(txEmptyEv), .modemEv(modemEv),
    .xoffEv(xoffEv), .xonEv(xonEv), .flowEv(flowEv), .srcEn(srcEn),
    .enhEn(enhEn), .fifoEn(fifoEn), .idRd(idRd), .lineRd(lineRd),
    .modemRd(modemRd), .txWr(txWr), .idVal(idVal), .irqOut(irqOut)
  );

  // behavioural reference model
  bit mLine = 0, mTx = 0, mModem = 0, mXoff = 0, mFlow = 0;
  logic [7:0] expId = 8'h01;
  bit expIrq = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLine = 0; mTx = 0; mModem = 0; mXoff = 0; mFlow = 0;
      expId = 8'h01; expIrq = 0;
    end else begin
      bit txShown;
      logic [5:0] c;
      txShown = (expId[5:0] == 6'h02);
      mLine  = lineErrEv | (mLine & !lineRd);
      mTx    = txEmptyEv | (mTx & !txWr & !(idRd & txShown));
      mModem = modemEv | (mModem & !modemRd);
      mFlow  = (enhEn & flowEv) | (mFlow & !modemRd);
      mXoff  = (enhEn & xoffEv) | (mXoff & !xonEv);
      if (mLine && srcEn[2])                 c = 6'h06;
      else if (rxTimeout && srcEn[0])        c = 6'h0C;
      else if (rxReady && srcEn[0])          c = 6'h04;
      else if (mTx && srcEn[1])              c = 6'h02;
      else if (mModem && srcEn[3])           c = 6'h00;
      else if (mXoff && srcEn[4] && enhEn)   c = 6'h10;
      else if (mFlow && srcEn[5] && enhEn)   c = 6'h20;
      else                                   c = 6'h01;
      expId  = {fifoEn, fifoEn, c};
      expIrq = (c != 6'h01);
    end
  end

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    checks++;
    if (idVal !== expId || irqOut !== expIrq) begin
      failures++;
      $display("FAIL %s model compare: id=%h irq=%b expected id=%h irq=%b",
               curReq, idVal, irqOut, expId, expIrq);
    end
  end

  task automatic tick();
    @(negedge clk);
    lineErrEv = 0; txEmptyEv = 0; modemEv = 0; xoffEv = 0; xonEv = 0;
    flowEv = 0; idRd = 0; lineRd = 0; modemRd = 0; txWr = 0;
  endtask

  // literal check; R4: irq must be the inverse of bit 0
  task automatic expectId(string req, logic [7:0] exp);
    checks++;
    if (idVal !== exp || irqOut !== !exp[0]) begin
      failures++;
      $display("FAIL %s literal: id=%h irq=%b expected id=%h irq=%b",
               req, idVal, irqOut, exp, !exp[0]);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #2 rstN = 0;
    curReq = "R1";
    tick(); tick(); tick();
    expectId("R1", 8'h01);
    rstN = 1;
    curReq = "R8";
    tick(); expectId("R8", 8'hC1);
    fifoEn = 0; tick(); expectId("R8", 8'h01);
    fifoEn = 1; tick(); expectId("R8", 8'hC1);

    srcEn = 6'h3F; enhEn = 1;
    curReq = "R2";
    flowEv = 1;    tick(); expectId("R3", 8'hE0);
    xoffEv = 1;    tick(); expectId("R2", 8'hD0);
    modemEv = 1;   tick(); expectId("R2", 8'hC0);
    txEmptyEv = 1; tick(); expectId("R2", 8'hC2);
    rxReady = 1;   tick(); expectId("R2", 8'hC4);
    curReq = "R5";
    rxTimeout = 1; tick(); expectId("R5", 8'hCC);
    curReq = "R2";
    lineErrEv = 1; tick(); expectId("R2", 8'hC6);
    curReq = "R9";
    lineRd = 1;    tick(); expectId("R9", 8'hCC);
    rxTimeout = 0; tick(); expectId("R5", 8'hC4);
    rxReady = 0;   tick(); expectId("R2", 8'hC2);
    curReq = "R10";
    idRd = 1;      tick(); expectId("R10", 8'hC0);
    curReq = "R9";
    modemRd = 1;   tick(); expectId("R9", 8'hD0);
    curReq = "R7";
    idRd = 1; lineRd = 1; modemRd = 1; tick(); expectId("R7", 8'hD0);
    tick(); expectId("R7", 8'hD0);
    xonEv = 1;     tick(); expectId("R7", 8'hC1);

    curReq = "R9";
    lineErrEv = 1; lineRd = 1; tick(); expectId("R9", 8'hC6);
    lineRd = 1;    tick(); expectId("R9", 8'hC1);
    modemEv = 1; modemRd = 1; tick(); expectId("R9", 8'hC0);
    modemRd = 1;   tick(); expectId("R9", 8'hC1);

    curReq = "R10";
    txEmptyEv = 1; tick(); expectId("R10", 8'hC2);
    lineErrEv = 1; tick(); expectId("R10", 8'hC6);
    idRd = 1;      tick(); expectId("R10", 8'hC6);
    lineRd = 1;    tick(); expectId("R10", 8'hC2);
    txWr = 1;      tick(); expectId("R10", 8'hC1);
    txEmptyEv = 1; tick(); expectId("R10", 8'hC2);
    modemEv = 1;   tick(); expectId("R10", 8'hC2);
    idRd = 1;      tick(); expectId("R10", 8'hC0);
    modemRd = 1;   tick(); expectId("R10", 8'hC1);
    txEmptyEv = 1; tick(); expectId("R10", 8'hC2);
    idRd = 1; txEmptyEv = 1; tick(); expectId("R10", 8'hC2);
    txWr = 1;      tick(); expectId("R10", 8'hC1);

    curReq = "R6";
    enhEn = 0;
    xoffEv = 1; flowEv = 1; tick(); expectId("R6", 8'hC1);
    enhEn = 1;     tick(); expectId("R6", 8'hC1);
    xoffEv = 1;    tick(); expectId("R6", 8'hD0);
    enhEn = 0;     tick(); expectId("R6", 8'hC1);
    enhEn = 1;     tick(); expectId("R7", 8'hD0);
    xonEv = 1;     tick(); expectId("R7", 8'hC1);

    curReq = "R11";
    srcEn = 6'h00;
    lineErrEv = 1; rxReady = 1; tick(); expectId("R11", 8'hC1);
    srcEn = 6'b000100; tick(); expectId("R11", 8'hC6);
    lineRd = 1;    tick(); expectId("R11", 8'hC1);
    srcEn = 6'b000001; tick(); expectId("R11", 8'hC4);
    rxReady = 0; srcEn = 6'h3F; tick(); expectId("R11", 8'hC1);

    curReq = "R12";
    modemEv = 1;
    expectId("R12", 8'hC1);
    tick(); expectId("R12", 8'hC0);
    modemRd = 1;   tick(); expectId("R12", 8'hC1);
    rxTimeout = 1; tick(); expectId("R12", 8'hCC);
    rxTimeout = 0; tick(); expectId("R12", 8'hC1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run=unfinished expected=finished");
      summary();
      $finish;
    end
  end
endmodule